// File: doc/BRIEF.md
# I2C Slave with Strap-Loaded Self-Addressing

This block is a byte-oriented I2C slave that oversamples SCL and SDA with the system clock. It finds START, repeated START and STOP conditions, compares the first byte of each transfer against its own 7-bit address, and then either takes bytes into a small register bank or sends bytes out of it. SDA is open-drain: the block only ever pulls it low through an output enable, and reads the resolved bus level back on a separate input.

Out of reset the slave answers at address 0000000. Up to four of these slaves can share one bus. A controller sends one broadcast write to the all-zero address, and its first data byte is a fixed command value (0xFF by default). Every slave that sees that write then copies its two strap inputs into address bits 1 and 0. The new address is used from the next START condition onward, and it stays in place until the next reset.

Top module: `strapI2cSlave`

## Requirements
- R1: While reset is held and right after it is released, SDA is released (`sdaOe` = 0) and the device address is 7'b0000000.
- R2: The first byte after START is the 7-bit address, MSB first, followed by the direction bit (1 = read, 0 = write). When the address matches, the slave pulls SDA low during the ninth SCL clock.
- R3: In a write, the slave acknowledges every data byte. The first data byte sets the register pointer to its low log2(NUM_REGS) bits. Each later byte is stored at the pointer, and the pointer then steps by one, wrapping from NUM_REGS-1 to 0.
- R4: In a read, the slave sends the register at the pointer MSB first, and the pointer steps by one after each byte with the same wrap-around.
- R5: A not-acknowledge from the master after a read byte ends the transfer. SDA then stays released (reads as 1) until the next START or STOP.
- R6: When the address does not match, the slave gives no acknowledge and keeps SDA released for the rest of that transfer, including any read data bytes, which the master then sees as 0xFF. No register is written.
- R7: A repeated START with no STOP before it begins a new transfer, and the address byte that follows it is decoded again.
- R8: A write to address 0000000 whose first data byte equals SELF_CMD (default 0xFF) latches strap inputs `strapLvl[1]` into address bit A1 and `strapLvl[0]` into A0. The upper five address bits stay 0. A strap level of 1 (node open) gives address bit 1, and 0 (node shorted) gives 0. This command byte does not change the register pointer.
- R9: The latched address takes effect at the next START or repeated START. Bytes that follow in the same command transfer are still acknowledged and written at the pointer. Changes on the strap inputs after the command have no effect.
- R10: Asserting reset returns the address to 0000000 until another self-address command is received.
- R11: The slave changes `sdaOe` only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Serial clock level seen on the bus |
| sdaIn | input | 1 | Resolved serial data level seen on the bus |
| strapLvl | input | 2 | Strap node levels: bit 1 feeds A1 and bit 0 feeds A0; 1 = open, 0 = shorted |
| sdaOe | output | 1 | Pulls SDA low when 1; SDA is released when 0 |

## Verification
The bench aims at the places where addressing and data direction meet. It writes after the self-address command inside the same transfer, where a design that switched address at once would drop the acknowledge. It sends a repeated START straight after the command, where a design that held off the new address until STOP would still answer at zero. It changes the straps after the command, which catches a design that reads the straps continuously instead of latching them.

It reads past the end of the bank to expose a pointer that does not wrap. It checks SDA after a final not-acknowledge, where a slave that loaded the next byte anyway would pull the line low. It addresses an absent device for both writes and reads, which catches any acknowledge, driven data bit or stray register write outside the slave's own address.

// File: rtl/strapI2cPkg.sv
package strapI2cPkg;

  localparam int ADDR_W  = 7;
  localparam int STRAP_W = 2;
  localparam int CNT_W   = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_W,
    ST_ACK_R,
    ST_WRITE,
    ST_READ,
    ST_IGNORE
  } ctlState_t;

  // datapath to control: bus events and byte status
  typedef struct packed {
    logic             sclFall;
    logic             startDet;
    logic             stopDet;
    logic [CNT_W-1:0] bitCnt;
    logic [7:0]       rxByte;
    logic             addrHit;
    logic             defHit;
  } busStat_t;

  // control to datapath: one-cycle strobes
  typedef struct packed {
    logic cntClr;
    logic cntRun;
    logic oeAck;
    logic oeRel;
    logic loadTx;
    logic shiftTx;
    logic setPtr;
    logic wrReg;
    logic incPtr;
    logic latchStrap;
  } strobe_t;

endpackage

// File: rtl/strapI2cData.sv
module strapI2cData
  import strapI2cPkg::*;
#(
  parameter int NUM_REGS = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclIn,
  input  logic               sdaIn,
  input  logic [STRAP_W-1:0] strapLvl,
  input  strobe_t            strb,
  output busStat_t           stat,
  output logic               sdaOe,
  output logic [STRAP_W-1:0] devLow
);

  localparam int PTR_W  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam int HIGH_W = ADDR_W - STRAP_W;

  // two-flop synchronisers plus one history stage for edge detection
  logic sclMeta, sclSync, sclPrev;
  logic sdaMeta, sdaSync, sdaPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclMeta <= 1'b1;
      sclSync <= 1'b1;
      sclPrev <= 1'b1;
      sdaMeta <= 1'b1;
      sdaSync <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclMeta <= sclIn;
      sclSync <= sclMeta;
      sclPrev <= sclSync;
      sdaMeta <= sdaIn;
      sdaSync <= sdaMeta;
      sdaPrev <= sdaSync;
    end
  end

  logic sclRise;
  assign sclRise = sclSync & ~sclPrev;

  // bit counter and receive shifter
  logic [CNT_W-1:0] bitCnt;
  logic [7:0]       rxByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
      rxByte <= '0;
    end else if (strb.cntClr) begin
      bitCnt <= '0;
    end else if (strb.cntRun && sclRise) begin
      bitCnt <= (bitCnt == CNT_W'(8)) ? '0 : bitCnt + CNT_W'(1);
      rxByte <= {rxByte[6:0], sdaSync};
    end
  end

  // address bits loaded from the straps: pending copy, applied at START
  logic [STRAP_W-1:0] pendLow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendLow <= '0;
      devLow  <= '0;
    end else begin
      if (strb.latchStrap) pendLow <= strapLvl;
      if (stat.startDet)   devLow  <= pendLow;
    end
  end

  // register bank with pointer
  logic [PTR_W-1:0]    regPtr;
  logic [7:0]          bank [NUM_REGS];
  logic [NUM_REGS-1:0] wrSel;

  generate
    for (genvar g = 0; g < NUM_REGS; g++) begin : gSel
      assign wrSel[g] = strb.wrReg && (regPtr == PTR_W'(g));
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) bank[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_REGS; i++) begin
        if (wrSel[i]) bank[i] <= rxByte;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regPtr <= '0;
    end else if (strb.setPtr) begin
      regPtr <= rxByte[PTR_W-1:0];
    end else if (strb.incPtr) begin
      regPtr <= regPtr + PTR_W'(1);
    end
  end

  // transmit shifter and open-drain enable
  logic [7:0] txShift;
  logic [7:0] rdData;
  assign rdData = bank[regPtr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      sdaOe   <= 1'b0;
    end else if (strb.oeRel) begin
      sdaOe <= 1'b0;
    end else if (strb.oeAck) begin
      sdaOe <= 1'b1;
    end else if (strb.loadTx) begin
      txShift <= rdData;
      sdaOe   <= ~rdData[7];
    end else if (strb.shiftTx) begin
      txShift <= {txShift[6:0], 1'b0};
      sdaOe   <= ~txShift[6];
    end
  end

  // status toward control
  always_comb begin
    stat.sclFall  = ~sclSync & sclPrev;
    stat.startDet = sclSync & sclPrev & sdaPrev & ~sdaSync;
    stat.stopDet  = sclSync & sclPrev & ~sdaPrev & sdaSync;
    stat.bitCnt   = bitCnt;
    stat.rxByte   = rxByte;
    stat.addrHit  = (rxByte[7:1] == {{HIGH_W{1'b0}}, devLow});
    stat.defHit   = (rxByte[7:1] == '0);
  end

endmodule

// File: rtl/strapI2cCtrl.sv
module strapI2cCtrl
  import strapI2cPkg::*;
#(
  parameter logic [7:0] SELF_CMD = 8'hFF
) (
  input  logic     clk,
  input  logic     rstN,
  input  busStat_t stat,
  output strobe_t  strb,
  output logic     inIgnore,
  output logic     busIdle
);

  ctlState_t state, stateNxt;
  logic      firstData, firstNxt;
  logic      cmdOk, cmdOkNxt;
  logic      endOfByte, endOfAck;

  assign endOfByte = stat.sclFall && (stat.bitCnt == CNT_W'(8));
  assign endOfAck  = stat.sclFall && (stat.bitCnt == CNT_W'(0));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      firstData <= 1'b0;
      cmdOk     <= 1'b0;
    end else begin
      state     <= stateNxt;
      firstData <= firstNxt;
      cmdOk     <= cmdOkNxt;
    end
  end

  always_comb begin
    strb     = '0;
    stateNxt = state;
    firstNxt = firstData;
    cmdOkNxt = cmdOk;
    if (stat.stopDet) begin
      strb.oeRel  = 1'b1;
      strb.cntClr = 1'b1;
      stateNxt    = ST_IDLE;
    end else if (stat.startDet) begin
      strb.oeRel  = 1'b1;
      strb.cntClr = 1'b1;
      stateNxt    = ST_ADDR;
    end else begin
      case (state)
        ST_ADDR: begin
          strb.cntRun = 1'b1;
          if (endOfByte) begin
            if (stat.addrHit) begin
              strb.oeAck = 1'b1;
              firstNxt   = 1'b1;
              cmdOkNxt   = stat.defHit && !stat.rxByte[0];
              stateNxt   = stat.rxByte[0] ? ST_ACK_R : ST_ACK_W;
            end else begin
              stateNxt = ST_IGNORE;
            end
          end
        end
        ST_ACK_W: begin
          strb.cntRun = 1'b1;
          if (endOfAck) begin
            strb.oeRel = 1'b1;
            stateNxt   = ST_WRITE;
          end
        end
        ST_ACK_R: begin
          strb.cntRun = 1'b1;
          if (endOfAck) begin
            strb.loadTx = 1'b1;
            strb.incPtr = 1'b1;
            stateNxt    = ST_READ;
          end
        end
        ST_WRITE: begin
          strb.cntRun = 1'b1;
          if (endOfByte) begin
            strb.oeAck = 1'b1;
            firstNxt   = 1'b0;
            if (firstData) begin
              if (cmdOk && stat.rxByte == SELF_CMD) strb.latchStrap = 1'b1;
              else                                  strb.setPtr     = 1'b1;
            end else begin
              strb.wrReg  = 1'b1;
              strb.incPtr = 1'b1;
            end
          end else if (endOfAck) begin
            strb.oeRel = 1'b1;
          end
        end
        ST_READ: begin
          strb.cntRun = 1'b1;
          if (stat.sclFall) begin
            if (stat.bitCnt == CNT_W'(8)) begin
              strb.oeRel = 1'b1;
            end else if (stat.bitCnt == CNT_W'(0)) begin
              // bit 0 of the shifter now holds the master's acknowledge
              if (!stat.rxByte[0]) begin
                strb.loadTx = 1'b1;
                strb.incPtr = 1'b1;
              end else begin
                stateNxt = ST_IGNORE;
              end
            end else begin
              strb.shiftTx = 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign inIgnore = (state == ST_IGNORE);
  assign busIdle  = (state == ST_IDLE);

endmodule

// File: rtl/strapI2cSlave.sv
module strapI2cSlave
  import strapI2cPkg::*;
#(
  parameter int         NUM_REGS = 4,
  parameter logic [7:0] SELF_CMD = 8'hFF
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclIn,
  input  logic               sdaIn,
  input  logic [STRAP_W-1:0] strapLvl,
  output logic               sdaOe
);

  busStat_t           stat;
  strobe_t            strb;
  logic               inIgnore;
  logic               busIdle;
  logic [STRAP_W-1:0] devLow;
  logic               startSeen;

  assign startSeen = stat.startDet;

  strapI2cData #(.NUM_REGS(NUM_REGS)) i_data (
    .clk      (clk),
    .rstN     (rstN),
    .sclIn    (sclIn),
    .sdaIn    (sdaIn),
    .strapLvl (strapLvl),
    .strb     (strb),
    .stat     (stat),
    .sdaOe    (sdaOe),
    .devLow   (devLow)
  );

  strapI2cCtrl #(.SELF_CMD(SELF_CMD)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .stat     (stat),
    .strb     (strb),
    .inIgnore (inIgnore),
    .busIdle  (busIdle)
  );

endmodule

// File: rtl/strapI2cChk.sv
module strapI2cChk (
  input logic       clk,
  input logic       rstN,
  input logic       sclIn,
  input logic       sdaOe,
  input logic       inIgnore,
  input logic       busIdle,
  input logic       startSeen,
  input logic [1:0] devLow
);

  // R1: the line is released coming out of reset
  a_r1_reset_release: assert property (@(posedge clk) !rstN |=> !sdaOe);

  // R11: the enable only moves while SCL is low
  a_r11_oe_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !sclIn);

  // R6: a transfer being ignored never pulls SDA
  a_r6_ignore_release: assert property (@(posedge clk) disable iff (!rstN)
    inIgnore |-> !sdaOe);

  // R9: address low bits change only right after a START
  a_r9_addr_at_start: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(devLow) |-> $past(startSeen));

  // R2: SDA is pulled only inside an active transfer
  a_r2_oe_in_transfer: assert property (@(posedge clk) disable iff (!rstN)
    sdaOe |-> !busIdle);

endmodule

bind strapI2cSlave strapI2cChk i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .sclIn     (sclIn),
  .sdaOe     (sdaOe),
  .inIgnore  (inIgnore),
  .busIdle   (busIdle),
  .startSeen (startSeen),
  .devLow    (devLow)
);

// File: tb/test_strapI2cSlave.sv
`timescale 1ns/1ps
module test_strapI2cSlave;

  localparam int Q = 10;            // clock cycles per quarter bit
  localparam int WATCHDOG = 150000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       mstScl = 1'b1;
  logic       mstSda = 1'b1;
  logic [1:0] strapLvl = 2'b00;
  logic       sdaOe;
  logic       sdaIn;

  always #2.5 clk = ~clk;

  assign sdaIn = mstSda & ~sdaOe;

  strapI2cSlave i_strapI2cSlave (
    .clk      (clk),
    .rstN     (rstN),
    .sclIn    (mstScl),
    .sdaIn    (sdaIn),
    .strapLvl (strapLvl),
    .sdaOe    (sdaOe)
  );

  int checks = 0;
  int errors = 0;
  int r11Viol = 0;
  bit finished = 1'b0;

  // scoreboard queues
  logic [7:0] expV[$];
  string      expT[$];
  logic [7:0] obsV[$];

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic expect_item(input logic [7:0] v, input string tag);
    expV.push_back(v);
    expT.push_back(tag);
  endtask

  // monitor: pops observations and compares with expectations
  always @(negedge clk) begin
    if (obsV.size() > 0) begin
      logic [7:0] o;
      o = obsV.pop_front();
      if (expV.size() == 0) begin
        check(o, 8'hxx, "scoreboard-empty");
      end else begin
        logic [7:0] e;
        string t;
        e = expV.pop_front();
        t = expT.pop_front();
        check(o, e, t);
      end
    end
  end

  // R11 watch: the enable must not move while SCL is high
  logic oePrev = 1'b0;
  always @(posedge clk) begin
    if (rstN && (sdaOe !== oePrev) && mstScl) r11Viol++;
    oePrev <= sdaOe;
  end

  task automatic waitQ(input int n = 1);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic busStart;
    mstSda = 1'b1; waitQ();
    mstScl = 1'b1; waitQ();
    mstSda = 1'b0; waitQ();
    mstScl = 1'b0; waitQ();
  endtask

  task automatic busStop;
    mstSda = 1'b0; waitQ();
    mstScl = 1'b1; waitQ();
    mstSda = 1'b1; waitQ();
  endtask

  // sends a byte and records the acknowledge level seen (0 = ACK)
  task automatic sendByte(input logic [7:0] b);
    logic ackLvl;
    for (int i = 7; i >= 0; i--) begin
      mstSda = b[i]; waitQ();
      mstScl = 1'b1; waitQ(2);
      mstScl = 1'b0; waitQ();
    end
    mstSda = 1'b1; waitQ();
    mstScl = 1'b1; waitQ();
    ackLvl = sdaIn; waitQ();
    mstScl = 1'b0; waitQ();
    obsV.push_back({7'd0, ackLvl});
  endtask

  // receives a byte, then answers ACK (nack=0) or NACK (nack=1)
  task automatic recvByte(input logic nack);
    logic [7:0] b;
    for (int i = 7; i >= 0; i--) begin
      mstSda = 1'b1; waitQ();
      mstScl = 1'b1; waitQ();
      b[i] = sdaIn; waitQ();
      mstScl = 1'b0; waitQ();
    end
    mstSda = nack; waitQ();
    mstScl = 1'b1; waitQ(2);
    mstScl = 1'b0; waitQ();
    mstSda = 1'b1;
    obsV.push_back(b);
  endtask

  task automatic wrAck(input logic [7:0] b, input string tag);
    expect_item(8'h00, tag);
    sendByte(b);
  endtask

  task automatic wrNack(input logic [7:0] b, input string tag);
    expect_item(8'h01, tag);
    sendByte(b);
  endtask

  task automatic rdExp(input logic [7:0] v, input logic nack, input string tag);
    expect_item(v, tag);
    recvByte(nack);
  endtask

  task automatic finishRun;
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual expired expected done");
    finishRun();
  end

  initial begin
    repeat (5) @(negedge clk);
    // R1: released during reset
    check({7'd0, sdaOe}, 8'h00, "R1 oe in reset");
    rstN = 1'b1;
    waitQ(2);
    check({7'd0, sdaOe}, 8'h00, "R1 oe after reset");

    // R1 R2 R3: default address, pointer 1, two data bytes
    busStart();
    wrAck(8'h00, "R1 default address write");
    wrAck(8'h01, "R3 pointer byte");
    wrAck(8'hA5, "R3 data byte 1");
    wrAck(8'h3C, "R3 data byte 2");
    busStop();

    // R7 R4 R5: set pointer, repeated START, read two bytes, final NACK
    busStart();
    wrAck(8'h00, "R2 address write");
    wrAck(8'h01, "R3 pointer byte");
    busStart();
    wrAck(8'h01, "R7 read address after repeated start");
    rdExp(8'hA5, 1'b0, "R4 read byte 1");
    rdExp(8'h3C, 1'b1, "R4 read byte 2");
    waitQ(2);
    expect_item(8'h01, "R5 sda after nack");
    obsV.push_back({7'd0, sdaIn});
    busStop();

    // R6: an absent address, write and read
    busStart();
    wrNack(8'h0A, "R6 mismatch address write");
    wrNack(8'h00, "R6 mismatch data byte");
    busStop();
    busStart();
    wrNack(8'h0B, "R6 mismatch address read");
    rdExp(8'hFF, 1'b1, "R6 mismatch read data");
    busStop();

    // R3: write wrapping from register 3 to register 0
    busStart();
    wrAck(8'h00, "R2 address write");
    wrAck(8'h03, "R3 pointer byte");
    wrAck(8'h11, "R3 write reg3");
    wrAck(8'h22, "R3 write wraps to reg0");
    busStop();
    // bank now: 22 A5 3C 11, pointer 1

    // R8 R9: self-address with A1 open, A0 shorted -> address 2
    strapLvl = 2'b10;
    busStart();
    wrAck(8'h00, "R8 command address");
    wrAck(8'hFF, "R8 command byte");
    wrAck(8'h77, "R9 byte after command still acked");
    busStart();
    wrNack(8'h00, "R9 new address at repeated start");
    busStop();
    strapLvl = 2'b11;

    // R8 R4: address 2, read from 1 with wrap past the end
    busStart();
    wrAck(8'h04, "R8 strap address write");
    wrAck(8'h01, "R3 pointer byte");
    busStart();
    wrAck(8'h05, "R8 strap address read");
    rdExp(8'h77, 1'b0, "R8 pointer unchanged by command");
    rdExp(8'h3C, 1'b0, "R4 read reg2");
    rdExp(8'h11, 1'b0, "R4 read reg3");
    rdExp(8'h22, 1'b1, "R4 read wraps to reg0");
    busStop();
    busStart();
    wrNack(8'h06, "R9 strap change ignored");
    busStop();

    // R10: reset returns to the default address
    @(negedge clk);
    rstN = 1'b0;
    waitQ();
    rstN = 1'b1;
    waitQ();
    busStart();
    wrAck(8'h00, "R10 default after reset");
    busStop();
    busStart();
    wrNack(8'h04, "R10 old address dropped");
    busStop();

    // R8: A1 shorted, A0 open -> address 1
    strapLvl = 2'b01;
    busStart();
    wrAck(8'h00, "R8 command address");
    wrAck(8'hFF, "R8 command byte");
    busStop();
    busStart();
    wrAck(8'h02, "R8 address one");
    busStop();
    busStart();
    wrNack(8'h00, "R8 zero address dropped");
    busStop();

    waitQ(2);
    wait (obsV.size() == 0);
    repeat (4) @(negedge clk);
    check(8'(expV.size()), 8'h00, "scoreboard leftover");
    check(8'(r11Viol), 8'h00, "R11 oe moved while scl high");
    finishRun();
  end

endmodule